// File: doc/BRIEF.md
# Streaming Five-Point Stencil Cache

This block sits between a raster-ordered sample source and a per-node update engine for an iterative grid solver. It takes one field sample and one speed sample per accepted beat. For each node it presents the node itself, its four orthogonal neighbours and the speed value that belongs to that node. Each external sample is read once. The rows needed to build the neighbourhood are held in two delay lines of `WIDTH-1` entries and a few single registers. The block also reports whether the presented node lies on the top, bottom, left or right edge of the image. Where a neighbour would fall outside the image, the centre value is presented in its place.

Both stream edges use valid/ready. On the input side, a beat is taken on a rising clock edge when `in_valid` and `in_ready` are both high. On the output side, a node is consumed when `out_valid` and `out_ready` are both high. While a presented node is not taken, every output holds and `in_ready` drops, so the whole delay structure stalls.

A node appears only after its lower neighbour has arrived. The first output therefore follows one full row plus one sample of input. At the end of the stream, `WIDTH` beats marked with `in_flush` push the last row out. Frames may follow each other back to back with no flush between them. The output carries a start-of-frame mark and the speed value with the same framing as the input. The update engine can therefore turn the output into the next instance's input, and two iterations run without external storage.

Top module: `stencil_cache`

## Requirements
- R1: `in_ready` is high when `out_valid` is low or `out_ready` is high, and low otherwise. While `out_valid` is high and `out_ready` is low, every output holds its value until the next cycle.
- R2: After reset, `out_valid` is low and `in_ready` is high. `out_valid` stays low until `WIDTH+1` beats have been accepted, and it is high right after beat `WIDTH+1` is accepted.
- R3: Presented centre values follow the input samples that are not flush beats, in input order. Each of these samples is presented exactly once.
- R4: For a node not on the left edge, `out_left` is the sample one column to its left. For a node not on the right edge, `out_right` is the sample one column to its right.
- R5: For a node not on the top edge, `out_up` is the sample in the same column one row above. For a node not on the bottom edge, `out_down` is the sample in the same column one row below.
- R6: On an edge, the neighbour that would fall outside the image is replaced by the centre value: left at column 0, right at column `WIDTH-1`, up at row 0, down at row `HEIGHT-1`.
- R7: The four edge flags follow the presented node's position. The top flag is high at row 0, the bottom flag at row `HEIGHT-1`, the left flag at column 0 and the right flag at column `WIDTH-1`. Position counts from the node marked start-of-frame, in raster order.
- R8: `out_spd` is the speed sample that arrived in the same beat as the presented centre.
- R9: A beat with `in_flush` high produces no node of its own. Its data and its `in_sof` value have no effect on any presented node. `WIDTH` flush beats drain the last row.
- R10: A beat with `in_sof` high restarts position at row 0, column 0. A second frame can follow the first immediately and is presented correctly.
- R11: `out_sof` is high exactly for the node that was input with `in_sof` high, and that node has the top and left flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| in_flush | input | 1 | Beat is a drain beat, not an image sample |
| in_sof | input | 1 | Beat is the first sample of a frame |
| in_phi | input | DW | Field sample |
| in_spd | input | SW | Speed sample |
| out_valid | output | 1 | Neighbourhood presented |
| out_ready | input | 1 | Consumer takes the presented node |
| out_sof | output | 1 | Presented node is the first of its frame |
| out_centre | output | DW | Centre value |
| out_left | output | DW | Left neighbour or centre on the left edge |
| out_right | output | DW | Right neighbour or centre on the right edge |
| out_up | output | DW | Upper neighbour or centre on the top edge |
| out_down | output | DW | Lower neighbour or centre on the bottom edge |
| out_spd | output | SW | Speed sample of the centre node |
| out_edge_top | output | 1 | Node is in row 0 |
| out_edge_bot | output | 1 | Node is in row HEIGHT-1 |
| out_edge_lft | output | 1 | Node is in column 0 |
| out_edge_rgt | output | 1 | Node is in column WIDTH-1 |

## Verification
The properties assume that each frame is exactly `WIDTH*HEIGHT` image beats. They also assume `in_sof` marks only a frame's first sample and that the drain at the end of the stream has `WIDTH` flush beats. The edge-replacement and start-of-frame properties depend on these rules, because position is derived by counting and never measured. The stimulus sends two whole frames back to back and then exactly `WIDTH` flush beats. It sets `in_sof` on those flush beats to show that the mark is ignored there. Idle input gaps and a pseudo-random `out_ready` exercise stalls without ever breaking the framing.

// File: rtl/stencil_pkg.sv
package stencil_pkg;

  // marker carried alongside each sample through the delay structure
  typedef struct packed {
    logic live;   // real image sample, not a drain beat
    logic sof;    // first sample of a frame
  } node_tag_t;

  localparam int unsigned TAG_W = $bits(node_tag_t);

  function automatic node_tag_t make_tag(input logic flush, input logic sof);
    node_tag_t t;
    t.live = ~flush;
    t.sof  = sof & ~flush;
    return t;
  endfunction

endpackage

// File: rtl/sc_delay_line.sv
module sc_delay_line #(
  parameter int unsigned W     = 12,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) stage[i] <= '0;
    end else if (en) begin
      stage[0] <= d;
      for (int i = 1; i < int'(DEPTH); i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[DEPTH-1];

endmodule

// File: rtl/sc_pos_track.sv
module sc_pos_track #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned HEIGHT = 5,
  localparam int unsigned CW = $clog2(WIDTH  > 1 ? WIDTH  : 2),
  localparam int unsigned RW = $clog2(HEIGHT > 1 ? HEIGHT : 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,        // a new live node becomes the centre
  input  logic adv_sof,    // that node starts a frame
  output logic edge_top,
  output logic edge_bot,
  output logic edge_lft,
  output logic edge_rgt
);

  localparam logic [CW-1:0] COL_LAST = CW'(WIDTH - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(HEIGHT - 1);

  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;

  // reset to the last position so an unmarked first frame still starts at 0,0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= COL_LAST;
      row_q <= ROW_LAST;
    end else if (adv) begin
      if (adv_sof) begin
        col_q <= '0;
        row_q <= '0;
      end else if (col_q == COL_LAST) begin
        col_q <= '0;
        row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  assign edge_top = (row_q == '0);
  assign edge_bot = (row_q == ROW_LAST);
  assign edge_lft = (col_q == '0);
  assign edge_rgt = (col_q == COL_LAST);

endmodule

// File: rtl/sc_nbr_select.sv
module sc_nbr_select #(
  parameter int unsigned DW = 12
) (
  input  logic [DW-1:0] centre,
  input  logic [DW-1:0] raw_lft,
  input  logic [DW-1:0] raw_rgt,
  input  logic [DW-1:0] raw_up,
  input  logic [DW-1:0] raw_dn,
  input  logic          edge_top,
  input  logic          edge_bot,
  input  logic          edge_lft,
  input  logic          edge_rgt,
  output logic [DW-1:0] sel_lft,
  output logic [DW-1:0] sel_rgt,
  output logic [DW-1:0] sel_up,
  output logic [DW-1:0] sel_dn
);

  logic [3:0]          at_edge;
  logic [3:0][DW-1:0]  raw;
  logic [3:0][DW-1:0]  sel;

  assign at_edge = {edge_bot, edge_top, edge_rgt, edge_lft};
  assign raw     = {raw_dn, raw_up, raw_rgt, raw_lft};

  for (genvar k = 0; k < 4; k++) begin : g_side
    assign sel[k] = at_edge[k] ? centre : raw[k];
  end

  assign sel_lft = sel[0];
  assign sel_rgt = sel[1];
  assign sel_up  = sel[2];
  assign sel_dn  = sel[3];

endmodule

// File: rtl/stencil_cache.sv
module stencil_cache
  import stencil_pkg::*;
#(
  parameter int unsigned DW     = 12,
  parameter int unsigned SW     = 12,
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned HEIGHT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_flush,
  input  logic          in_sof,
  input  logic [DW-1:0] in_phi,
  input  logic [SW-1:0] in_spd,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_sof,
  output logic [DW-1:0] out_centre,
  output logic [DW-1:0] out_left,
  output logic [DW-1:0] out_right,
  output logic [DW-1:0] out_up,
  output logic [DW-1:0] out_down,
  output logic [SW-1:0] out_spd,
  output logic          out_edge_top,
  output logic          out_edge_bot,
  output logic          out_edge_lft,
  output logic          out_edge_rgt
);

  // the centre sits WIDTH beats behind the newest sample, which is one register deep
  localparam int unsigned ROWBUF_D = WIDTH - 1;
  localparam int unsigned CTR_LAG  = WIDTH + 1;

  logic      accept, fire, taken_q;
  node_tag_t tag_in, tag_pre, tag_ctr;
  logic [TAG_W-1:0] tag_pre_v, tag_ctr_v;

  logic [DW-1:0] t_dn, t_rgt, t_ctr, t_lft, t_up;

  assign accept = in_valid & in_ready;
  assign fire   = out_valid & out_ready;
  assign tag_in = make_tag(in_flush, in_sof);

  // field taps: newest -> right -> centre -> left -> above
  sc_delay_line #(.W(DW), .DEPTH(1)) u_head (
    .clk(clk), .rst_n(rst_n), .en(accept), .d(in_phi), .q(t_dn));
  sc_delay_line #(.W(DW), .DEPTH(ROWBUF_D)) u_row_near (
    .clk(clk), .rst_n(rst_n), .en(accept), .d(t_dn), .q(t_rgt));
  sc_delay_line #(.W(DW), .DEPTH(1)) u_ctr_reg (
    .clk(clk), .rst_n(rst_n), .en(accept), .d(t_rgt), .q(t_ctr));
  sc_delay_line #(.W(DW), .DEPTH(1)) u_lft_reg (
    .clk(clk), .rst_n(rst_n), .en(accept), .d(t_ctr), .q(t_lft));
  sc_delay_line #(.W(DW), .DEPTH(ROWBUF_D)) u_row_far (
    .clk(clk), .rst_n(rst_n), .en(accept), .d(t_lft), .q(t_up));

  // speed follows the centre
  sc_delay_line #(.W(SW), .DEPTH(CTR_LAG)) u_spd_dly (
    .clk(clk), .rst_n(rst_n), .en(accept), .d(in_spd), .q(out_spd));

  // markers: split so the tracker sees the next centre's marker before the shift
  sc_delay_line #(.W(TAG_W), .DEPTH(WIDTH)) u_tag_pre (
    .clk(clk), .rst_n(rst_n), .en(accept), .d(tag_in), .q(tag_pre_v));
  sc_delay_line #(.W(TAG_W), .DEPTH(1)) u_tag_ctr (
    .clk(clk), .rst_n(rst_n), .en(accept), .d(tag_pre_v), .q(tag_ctr_v));

  assign tag_pre = node_tag_t'(tag_pre_v);
  assign tag_ctr = node_tag_t'(tag_ctr_v);

  // a presented centre is consumed once; a new shift brings the next one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      taken_q <= 1'b0;
    else if (accept) taken_q <= 1'b0;
    else if (fire)   taken_q <= 1'b1;
  end

  assign out_valid = tag_ctr.live & ~taken_q;
  assign in_ready  = ~out_valid | out_ready;
  assign out_sof   = tag_ctr.sof;
  assign out_centre = t_ctr;

  sc_pos_track #(.WIDTH(WIDTH), .HEIGHT(HEIGHT)) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (accept & tag_pre.live),
    .adv_sof  (tag_pre.sof),
    .edge_top (out_edge_top),
    .edge_bot (out_edge_bot),
    .edge_lft (out_edge_lft),
    .edge_rgt (out_edge_rgt)
  );

  sc_nbr_select #(.DW(DW)) u_sel (
    .centre   (t_ctr),
    .raw_lft  (t_lft),
    .raw_rgt  (t_rgt),
    .raw_up   (t_up),
    .raw_dn   (t_dn),
    .edge_top (out_edge_top),
    .edge_bot (out_edge_bot),
    .edge_lft (out_edge_lft),
    .edge_rgt (out_edge_rgt),
    .sel_lft  (out_left),
    .sel_rgt  (out_right),
    .sel_up   (out_up),
    .sel_dn   (out_down)
  );

endmodule

// File: rtl/stencil_cache_chk.sv
module stencil_cache_chk #(
  parameter int unsigned DW     = 12,
  parameter int unsigned SW     = 12,
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned HEIGHT = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_flush,
  input logic          in_sof,
  input logic [DW-1:0] in_phi,
  input logic [SW-1:0] in_spd,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_sof,
  input logic [DW-1:0] out_centre,
  input logic [DW-1:0] out_left,
  input logic [DW-1:0] out_right,
  input logic [DW-1:0] out_up,
  input logic [DW-1:0] out_down,
  input logic [SW-1:0] out_spd,
  input logic          out_edge_top,
  input logic          out_edge_bot,
  input logic          out_edge_lft,
  input logic          out_edge_rgt
);

  localparam int unsigned FW = $clog2(WIDTH + 2);
  localparam logic [FW-1:0] FILL_MAX = FW'(WIDTH + 1);

  logic [FW-1:0] fill_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_cnt <= '0;
    else if (in_valid && in_ready && fill_cnt != FILL_MAX) fill_cnt <= fill_cnt + 1'b1;
  end

  p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_centre) && $stable(out_spd)
      && $stable(out_left) && $stable(out_right) && $stable(out_up) && $stable(out_down)
      && $stable(out_sof));

  p_backpress_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> fill_cnt == FILL_MAX);

  p_edge_lft_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_edge_lft |-> out_left == out_centre);

  p_edge_rgt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_edge_rgt |-> out_right == out_centre);

  p_edge_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_edge_top |-> out_up == out_centre);

  p_edge_bot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_edge_bot |-> out_down == out_centre);

  p_rows_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && HEIGHT > 1 |-> !(out_edge_top && out_edge_bot));

  p_cols_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && WIDTH > 1 |-> !(out_edge_lft && out_edge_rgt));

  p_sof_corner_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> out_edge_top && out_edge_lft);

endmodule

bind stencil_cache stencil_cache_chk #(
  .DW(DW), .SW(SW), .WIDTH(WIDTH), .HEIGHT(HEIGHT)
) u_chk (.*);

// File: tb/stencil_cache_tb.sv
`timescale 1ns/1ps
module stencil_cache_tb_top;

  localparam int W  = 8;
  localparam int H  = 5;
  localparam int DW = 12;

  typedef struct packed {
    logic sof, top, bot, lft, rgt;
    logic [11:0] ctr, l, r, u, d, sp;
  } node_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_flush = 1'b0, in_sof = 1'b0, out_ready = 1'b0;
  logic [11:0] in_phi = '0, in_spd = '0;
  logic in_ready, out_valid, out_sof;
  logic [11:0] out_centre, out_left, out_right, out_up, out_down, out_spd;
  logic out_edge_top, out_edge_bot, out_edge_lft, out_edge_rgt;

  int n_chk = 0, n_err = 0, n_out = 0, acc = 0;
  bit fill0_done = 0, fill1_done = 0;
  node_t exp_q[$];

  always #2 clk = ~clk;

  stencil_cache #(.DW(DW), .SW(12), .WIDTH(W), .HEIGHT(H)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] phi_of(int f, int r, int c);
    return 12'((f*97 + r*29 + c*7 + r*c*3 + 5) % 4096);
  endfunction

  function automatic logic [11:0] spd_of(int f, int r, int c);
    return 12'((f*13 + r*53 + c*17 + 100) % 4096);
  endfunction

  function automatic node_t expect_node(int f, int r, int c);
    node_t e;
    e.sof = (r == 0 && c == 0);
    e.top = (r == 0);  e.bot = (r == H-1);
    e.lft = (c == 0);  e.rgt = (c == W-1);
    e.ctr = phi_of(f, r, c);
    e.l   = (c == 0)   ? e.ctr : phi_of(f, r, c-1);
    e.r   = (c == W-1) ? e.ctr : phi_of(f, r, c+1);
    e.u   = (r == 0)   ? e.ctr : phi_of(f, r-1, c);
    e.d   = (r == H-1) ? e.ctr : phi_of(f, r+1, c);
    e.sp  = spd_of(f, r, c);
    return e;
  endfunction

  // driver: one beat, with occasional idle cycles before it
  task automatic send(input logic [11:0] p, input logic [11:0] s, input logic sof, input logic fl);
    bit took;
    @(negedge clk); #1;
    if (acc == W && !fill0_done) begin
      fill0_done = 1;
      chk(out_valid == 1'b0, "R2 still filling", 32'(out_valid), 0);
    end
    if (acc == W+1 && !fill1_done) begin
      fill1_done = 1;
      chk(out_valid == 1'b1, "R2 first node after fill", 32'(out_valid), 1);
    end
    if (acc % 5 == 3) begin
      in_valid = 1'b0;
      @(negedge clk); #1;
    end
    in_valid = 1'b1; in_phi = p; in_spd = s; in_sof = sof; in_flush = fl;
    forever begin
      took = in_ready;
      @(posedge clk);
      if (took) break;
      @(negedge clk); #1;
    end
    acc++;
  endtask

  // monitor: drives back-pressure, checks stalls and compares against the scoreboard
  logic [15:0] lfsr = 16'hACE1;
  node_t held;
  bit held_ok = 0;
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[3];
      #1;
      if (rst_n) begin
        node_t a;
        a = '{out_sof, out_edge_top, out_edge_bot, out_edge_lft, out_edge_rgt,
              out_centre, out_left, out_right, out_up, out_down, out_spd};
        if (held_ok && out_valid)
          chk(a == held, "R1 output held under stall", a.ctr, held.ctr);
        if (out_valid && !out_ready) begin
          chk(in_ready == 1'b0, "R1 in_ready low under stall", 32'(in_ready), 0);
          held = a; held_ok = 1;
        end else held_ok = 0;
        if (out_valid && out_ready) begin
          n_out++;
          if (exp_q.size() == 0) begin
            chk(0, "R9 unexpected extra node", a.ctr, 0);
          end else begin
            node_t e;
            bit in_f1;
            e = exp_q.pop_front();
            in_f1 = (n_out > W*H);
            chk(a.ctr == e.ctr, "R3 centre order", a.ctr, e.ctr);
            chk(a.sp == e.sp, "R8 speed alignment", a.sp, e.sp);
            chk({a.top, a.bot, a.lft, a.rgt} == {e.top, e.bot, e.lft, e.rgt},
                "R7 edge flags", {a.top, a.bot, a.lft, a.rgt}, {e.top, e.bot, e.lft, e.rgt});
            chk(a.sof == e.sof, in_f1 ? "R10 second frame start" : "R11 start mark", a.sof, e.sof);
            if (e.lft || e.rgt)
              chk(a.l == e.l && a.r == e.r, "R6 side replacement", {a.l, a.r}, {e.l, e.r});
            else
              chk(a.l == e.l && a.r == e.r, "R4 left/right", {a.l, a.r}, {e.l, e.r});
            if (e.top || e.bot)
              chk(a.u == e.u && a.d == e.d, "R6 row replacement", {a.u, a.d}, {e.u, e.d});
            else
              chk(a.u == e.u && a.d == e.d, "R5 up/down", {a.u, a.d}, {e.u, e.d});
          end
        end
      end
    end
  end

  initial begin
    int wd;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R2 reset out_valid", 32'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 reset in_ready", 32'(in_ready), 1);
    for (int f = 0; f < 2; f++)
      for (int r = 0; r < H; r++)
        for (int c = 0; c < W; c++) begin
          exp_q.push_back(expect_node(f, r, c));
          send(phi_of(f, r, c), spd_of(f, r, c), (r == 0 && c == 0), 1'b0);
        end
    // drain beats carry junk and a stray start mark that must be ignored (R9)
    for (int k = 0; k < W; k++)
      send(12'hF00 + 12'(k), 12'h0E0 + 12'(k), 1'b1, 1'b1);
    @(negedge clk);
    in_valid = 1'b0; in_flush = 1'b0; in_sof = 1'b0;
    wd = 0;
    while (exp_q.size() != 0 && wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    if (wd >= 100000) chk(0, "R3 watchdog expired", exp_q.size(), 0);
    repeat (20) @(posedge clk);
    chk(n_out == 2*W*H, "R9 node count after drain", n_out, 2*W*H);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule